// File: doc/BRIEF.md
# NAND page ECC generator

This block sits beside a NAND flash data bus and builds a single-error-correcting Hamming code over the bytes that cross it. The code is built one 256-byte chunk at a time. Each finished chunk leaves three code bytes, and there are two storage slots, so a 512-byte page yields six code bytes. The host reads them back later and compares them with the code held in the spare area. Error correction is done by the host, not by this block.

A two-bit mode input steers the block. The host first clears it. It then parks it in off and switches it to accumulate while the page data streams. It goes back to off and then to read-out. In read-out, every data-register read returns the next stored code byte.

Top module: `nand_ecc_gen`

## Requirements
- R1: `ecc_mode` encodes 2'b11 = clear, 2'b01 = accumulate, 2'b10 = read-out, 2'b00 = off. While in clear, all parity state, the chunk counter, the slot index and the read pointer return to zero. All six stored code bytes become 8'hFF, and `ecc_rdata` shows 8'hFF from the next cycle.
- R2: A byte is folded into the code only in a cycle where `bus_xfer` is high and the mode is accumulate. A byte strobed in any other mode leaves the code unchanged.
- R3: For each bit k (0..7) of the byte's position inside its chunk, there is a pair of line parities. One is the XOR of the bits of all bytes whose position has bit k set; the other covers the bytes with bit k clear. For each bit j (0..2) of the bit position inside a byte, there is a pair of column parities built the same way over bit positions.
- R4: Code byte 0 of a chunk holds the line pairs for k=0..3 and code byte 1 holds k=4..7. For pair k, bit 2(k mod 4) is the "clear" parity and the next bit up is the "set" parity. Code byte 2 bits [5:0] hold the column pairs, with bit 2j "clear" and bit 2j+1 "set"; bits [7:6] are 1. Every parity bit is stored inverted, so 512 bytes of 8'hFF give six 8'hFF code bytes.
- R5: The counted byte that completes 256 is included in its chunk's code. That code is then latched into the current slot, and the next counted byte starts a fresh chunk in the next slot. A chunk that is not complete leaves its slot at 8'hFF.
- R6: Once both slots are filled, further counted bytes are ignored until the next clear.
- R7: Read-out is valid only when it is entered from off. Each `dreg_rd` then puts the next code byte on `ecc_rdata` one cycle later. The order is chunk 0 bytes 0,1,2 and then chunk 1 bytes 0,1,2. Entering from off restarts at chunk 0 byte 0, and this includes a read made in the entry cycle itself.
- R8: A read after the sixth code byte returns 8'hFF.
- R9: If the mode reaches read-out straight from accumulate or clear, reads are ignored and `ecc_rdata` keeps its value. This lasts until the mode passes through off.
- R10: `ecc_rdata` changes only after a read in read-out or after clear.
- R11: Asynchronous active-low reset gives the same state as clear, with `ecc_rdata` = 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_mode | input | 2 | Mode: 11 clear, 01 accumulate, 10 read-out, 00 off |
| bus_xfer | input | 1 | A data byte crosses the flash bus this cycle |
| bus_byte | input | 8 | The byte on the flash bus |
| dreg_rd | input | 1 | Data-register read strobe |
| ecc_rdata | output | 8 | Code byte returned by the latest accepted read |

## Verification
Two pairs of events can land in the same cycle. The first is the 256th counted byte of chunk 0 and the latching of its code, with the first byte of chunk 1 following on the very next cycle. The bench streams the page so that bytes 255 and 256 arrive back to back. The second chunk's code must come out independent of the first chunk's data, and the bench judges this against a model computed per chunk. The second pair is the switch into read-out and a read in that same cycle. The bench raises both together, both on first entry and on re-entry after an interrupted read-out, and expects chunk 0 byte 0 rather than a stale pointer position.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_ACCUM = 2'b01,
        MODE_READ  = 2'b10,
        MODE_CLEAR = 2'b11
    } ecc_mode_e;

    // three bit-position pairs over an 8-bit byte
    localparam int COL_W = 6;
endpackage

// File: rtl/ecc_byte_parity.sv
module ecc_byte_parity #(
    parameter int IDX_W = 8
) (
    input  logic [7:0]         byte_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [2*IDX_W-1:0] lp_o,
    output logic [ecc_pkg::COL_W-1:0] cp_o
);
    logic bp;

    always_comb begin
        bp   = ^byte_i;
        lp_o = '0;
        cp_o = '0;
        for (int k = 0; k < IDX_W; k++) begin
            lp_o[2*k]   = bp & ~idx_i[k];
            lp_o[2*k+1] = bp &  idx_i[k];
        end
        for (int b = 0; b < 8; b++) begin
            for (int j = 0; j < 3; j++) begin
                if (((b >> j) & 1) == 1) cp_o[2*j+1] = cp_o[2*j+1] ^ byte_i[b];
                else                     cp_o[2*j]   = cp_o[2*j]   ^ byte_i[b];
            end
        end
    end
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
    parameter int CHUNK_BYTES = 256,
    parameter int NUM_CHUNKS  = 2,
    localparam int IDX_W   = $clog2(CHUNK_BYTES),
    localparam int LP_W    = 2 * IDX_W,
    localparam int PAR_W   = LP_W + ecc_pkg::COL_W,
    localparam int BPC     = (PAR_W + 7) / 8,
    localparam int STORE_W = 8 * BPC,
    localparam int SLOT_W  = $clog2(NUM_CHUNKS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          byte_valid_i,
    input  logic [7:0]                    byte_i,
    output logic [NUM_CHUNKS*STORE_W-1:0] slot_vec_o
);
    typedef struct packed {
        logic [LP_W-1:0]                      lp;
        logic [ecc_pkg::COL_W-1:0]            cp;
        logic [IDX_W-1:0]                     idx;
        logic [SLOT_W-1:0]                    slot;
        logic [NUM_CHUNKS-1:0][STORE_W-1:0]   store;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [LP_W-1:0]           c_lp;
    logic [ecc_pkg::COL_W-1:0] c_cp;
    logic [LP_W-1:0]           n_lp;
    logic [ecc_pkg::COL_W-1:0] n_cp;
    logic [STORE_W-1:0]        packed_code;

    ecc_byte_parity #(.IDX_W(IDX_W)) i_par (
        .byte_i (byte_i),
        .idx_i  (acc_q.idx),
        .lp_o   (c_lp),
        .cp_o   (c_cp)
    );

    always_comb begin
        acc_d       = acc_q;
        n_lp        = acc_q.lp ^ c_lp;
        n_cp        = acc_q.cp ^ c_cp;
        packed_code = '1;
        packed_code[PAR_W-1:0] = ~{n_cp, n_lp};
        if (clear_i) begin
            acc_d.lp    = '0;
            acc_d.cp    = '0;
            acc_d.idx   = '0;
            acc_d.slot  = '0;
            acc_d.store = '1;
        end else if (byte_valid_i && (acc_q.slot < SLOT_W'(NUM_CHUNKS))) begin
            if (acc_q.idx == IDX_W'(CHUNK_BYTES - 1)) begin
                for (int s = 0; s < NUM_CHUNKS; s++) begin
                    if (acc_q.slot == SLOT_W'(s)) acc_d.store[s] = packed_code;
                end
                acc_d.lp   = '0;
                acc_d.cp   = '0;
                acc_d.idx  = '0;
                acc_d.slot = acc_q.slot + SLOT_W'(1);
            end else begin
                acc_d.lp  = n_lp;
                acc_d.cp  = n_cp;
                acc_d.idx = acc_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.lp    <= '0;
            acc_q.cp    <= '0;
            acc_q.idx   <= '0;
            acc_q.slot  <= '0;
            acc_q.store <= '1;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign slot_vec_o = acc_q.store;
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout #(
    parameter int NUM_BYTES = 6,
    localparam int PTR_W = $clog2(NUM_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   enter_i,
    input  logic                   rd_i,
    input  logic [8*NUM_BYTES-1:0] code_i,
    output logic [7:0]             rd_data_o
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [7:0]       data;
    } ro_t;

    ro_t ro_d, ro_q;
    logic [PTR_W-1:0] base;
    logic [7:0]       sel;

    always_comb begin
        ro_d = ro_q;
        base = enter_i ? '0 : ro_q.ptr;
        sel  = 8'hFF;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (base == PTR_W'(i)) sel = code_i[8*i +: 8];
        end
        if (clear_i) begin
            ro_d.ptr  = '0;
            ro_d.data = 8'hFF;
        end else if (rd_i) begin
            ro_d.data = sel;
            ro_d.ptr  = (base < PTR_W'(NUM_BYTES)) ? base + PTR_W'(1) : base;
        end else if (enter_i) begin
            ro_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ro_q.ptr  <= '0;
            ro_q.data <= 8'hFF;
        end else begin
            ro_q <= ro_d;
        end
    end

    assign rd_data_o = ro_q.data;
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    parameter int NUM_CHUNKS  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ecc_mode,
    input  logic       bus_xfer,
    input  logic [7:0] bus_byte,
    input  logic       dreg_rd,
    output logic [7:0] ecc_rdata
);
    localparam int IDX_W   = $clog2(CHUNK_BYTES);
    localparam int PAR_W   = 2 * IDX_W + COL_W;
    localparam int BPC     = (PAR_W + 7) / 8;
    localparam int TOTAL_B = NUM_CHUNKS * BPC;

    typedef struct packed {
        ecc_mode_e prev;
        logic      armed;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    ecc_mode_e mode;
    logic      clear_en, accum_en, ro_ok, ro_enter;
    logic [8*TOTAL_B-1:0] code_vec;

    always_comb begin
        mode     = ecc_mode_e'(ecc_mode);
        clear_en = (mode == MODE_CLEAR);
        accum_en = (mode == MODE_ACCUM) && bus_xfer;
        ro_enter = (mode == MODE_READ) && (ctl_q.prev == MODE_OFF);
        ro_ok    = (mode == MODE_READ) && ((ctl_q.prev == MODE_OFF) || ctl_q.armed);
        ctl_d.prev  = mode;
        ctl_d.armed = ro_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.prev  <= MODE_OFF;
            ctl_q.armed <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ecc_accum #(
        .CHUNK_BYTES (CHUNK_BYTES),
        .NUM_CHUNKS  (NUM_CHUNKS)
    ) i_accum (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_en),
        .byte_valid_i (accum_en),
        .byte_i       (bus_byte),
        .slot_vec_o   (code_vec)
    );

    ecc_readout #(
        .NUM_BYTES (TOTAL_B)
    ) i_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_en),
        .enter_i   (ro_enter),
        .rd_i      (dreg_rd && ro_ok),
        .code_i    (code_vec),
        .rd_data_o (ecc_rdata)
    );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
    parameter int NUM_BYTES = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ecc_mode,
    input logic       dreg_rd,
    input logic [7:0] ecc_rdata
);
    logic [1:0] prev_q;
    logic       armed_q;
    logic [7:0] cnt_q;
    logic       ok, ent;
    logic [7:0] base;

    assign ok   = (ecc_mode == 2'b10) && ((prev_q == 2'b00) || armed_q);
    assign ent  = (ecc_mode == 2'b10) && (prev_q == 2'b00);
    assign base = ent ? 8'd0 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 2'b00;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            prev_q  <= ecc_mode;
            armed_q <= ok;
            if (ecc_mode == 2'b11)                     cnt_q <= '0;
            else if (ok && dreg_rd && base < 8'd200)   cnt_q <= base + 8'd1;
            else if (ent)                              cnt_q <= '0;
        end
    end

    // R1
    a_r1_clear_ff: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_mode == 2'b11 |=> ecc_rdata == 8'hFF);

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dreg_rd && ecc_mode == 2'b10) && ecc_mode != 2'b11) |=> $stable(ecc_rdata));

    // R9
    a_r9_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b10 && !ok) |=> $stable(ecc_rdata));

    // R8
    a_r8_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && dreg_rd && base >= 8'(NUM_BYTES)) |=> ecc_rdata == 8'hFF);

    // R4
    a_r4_pad_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && dreg_rd && (base == 8'd2 || base == 8'd5)) |=> ecc_rdata[7:6] == 2'b11);
endmodule

bind nand_ecc_gen nand_ecc_gen_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_mode  (ecc_mode),
    .dreg_rd   (dreg_rd),
    .ecc_rdata (ecc_rdata)
);

// File: tb/test_nand_ecc_gen.sv
module test_nand_ecc_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ecc_mode = 2'b00;
    logic       bus_xfer = 1'b0;
    logic [7:0] bus_byte = 8'h00;
    logic       dreg_rd = 1'b0;
    logic [7:0] ecc_rdata;

    int total = 0;
    int bad   = 0;

    logic [7:0] pg [0:511];
    logic [7:0] expb [0:5];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       due = 1'b0;

    always #4 clk = ~clk;

    nand_ecc_gen i_nand_ecc_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .ecc_mode  (ecc_mode),
        .bus_xfer  (bus_xfer),
        .bus_byte  (bus_byte),
        .dreg_rd   (dreg_rd),
        .ecc_rdata (ecc_rdata)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // reference code for chunk c of pg
    task automatic build_model();
        for (int c = 0; c < 2; c++) begin
            logic [15:0] lp;
            logic [5:0]  cp;
            lp = '0;
            cp = '0;
            for (int i = 0; i < 256; i++) begin
                logic [7:0] b;
                logic       p;
                b = pg[c*256 + i];
                p = ^b;
                for (int k = 0; k < 8; k++) begin
                    if (((i >> k) & 1) == 1) lp[2*k+1] ^= p;
                    else                     lp[2*k]   ^= p;
                end
                for (int bit_i = 0; bit_i < 8; bit_i++) begin
                    for (int j = 0; j < 3; j++) begin
                        if (((bit_i >> j) & 1) == 1) cp[2*j+1] ^= b[bit_i];
                        else                         cp[2*j]   ^= b[bit_i];
                    end
                end
            end
            expb[c*3 + 0] = ~lp[7:0];
            expb[c*3 + 1] = ~lp[15:8];
            expb[c*3 + 2] = {2'b11, ~cp};
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) due <= dreg_rd;

    always @(negedge clk) begin
        if (due) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R7: unexpected read, got %02h expected none", ecc_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(ecc_rdata, e, t);
            end
        end
    end

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        ecc_mode = m;
    endtask

    task automatic rd(input logic [1:0] m, input logic [7:0] exp, input string tag);
        @(negedge clk);
        ecc_mode = m;
        dreg_rd  = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        dreg_rd = 1'b0;
    endtask

    task automatic stream(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 7) == 3) begin
                @(negedge clk);
                bus_xfer = 1'b0;
                bus_byte = 8'hA5;
            end
            @(negedge clk);
            bus_xfer = 1'b1;
            bus_byte = pg[i];
        end
        @(negedge clk);
        bus_xfer = 1'b0;
    endtask

    task automatic junk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_xfer = 1'b1;
            bus_byte = 8'(i * 13 + 7);
        end
        @(negedge clk);
        bus_xfer = 1'b0;
    endtask

    task automatic read_all(input string tag);
        rd(2'b10, expb[0], {tag, " entry read"});
        for (int i = 1; i < 6; i++) rd(2'b10, expb[i], tag);
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ecc_rdata, 8'hFF, "R11 reset value");

        // page A: distinct chunk patterns
        for (int i = 0; i < 256; i++) pg[i] = 8'((i * 37 + 11) & 255);
        for (int i = 256; i < 512; i++) pg[i] = 8'(i) ^ 8'h5A;
        build_model();

        set_mode(2'b11);
        set_mode(2'b00);
        junk(10);                      // R2 bytes in off are ignored
        set_mode(2'b01);
        stream(512, 1'b1);             // bytes 255/256 back to back (R5)
        junk(12);                      // R6 both slots full
        set_mode(2'b00);
        junk(5);                       // R2
        rd(2'b10, expb[0], "R7 read in entry cycle");
        rd(2'b10, expb[1], "R7 order");
        rd(2'b10, expb[2], "R3 chunk0 column byte");
        set_mode(2'b01);
        rd(2'b10, expb[2], "R9 entry from accumulate ignored");
        rd(2'b10, expb[2], "R9 still ignored");
        set_mode(2'b00);
        rd(2'b10, expb[0], "R7 restart on re-entry");
        rd(2'b10, expb[1], "R3 chunk0 line high");
        rd(2'b10, expb[2], "R4 chunk0 byte2");
        rd(2'b10, expb[3], "R5 chunk1 byte0");
        rd(2'b10, expb[4], "R5 chunk1 byte1");
        rd(2'b10, expb[5], "R6 chunk1 byte2");
        rd(2'b10, 8'hFF, "R8 past end");
        rd(2'b10, 8'hFF, "R8 past end again");

        // clear wipes stored code
        set_mode(2'b11);
        @(negedge clk);
        check(ecc_rdata, 8'hFF, "R1 clear output");
        set_mode(2'b00);
        for (int i = 0; i < 6; i++) expb[i] = 8'hFF;
        read_all("R1 cleared store");

        // partial chunk leaves slots erased
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b01);
        stream(100, 1'b0);
        set_mode(2'b00);
        rd(2'b10, 8'hFF, "R5 partial chunk b0");
        rd(2'b10, 8'hFF, "R5 partial chunk b1");
        rd(2'b10, 8'hFF, "R5 partial chunk b2");

        // erased page
        for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
        build_model();
        for (int i = 0; i < 6; i++) check(expb[i], 8'hFF, "R4 model erased code");
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b01);
        stream(512, 1'b0);
        set_mode(2'b00);
        read_all("R4 erased page");

        // single bit flip in chunk 1
        pg[256 + 77][3] = 1'b0;
        build_model();
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b01);
        stream(512, 1'b1);
        set_mode(2'b00);
        read_all("R3 single flip");

        repeat (4) @(negedge clk);
        check(8'(exp_q.size()), 8'd0, "R7 all reads answered");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule